// File: doc/BRIEF.md
# Line Mirror Buffer

This block flips each video line end for end, as the horizontal half-turn stage between two passes of a recursive smoothing filter. A line goes into one on-chip single-port memory. It comes back out in reverse order while the next line is being written. The memory is clocked at twice the pixel rate. Each pixel period takes two clock cycles: a read phase, which fetches the stored pixel, and a write phase, which puts the new pixel at the same address. One line of storage is therefore enough. The address counter counts up on one line and down on the next, so each fetch returns the previous line's pixels last-to-first.

The input stream uses a valid/ready handshake. `in_ready` is the phase indicator. It is high in the read phase and low for the write phase that follows each accepted pixel. A source can hold `in_valid` high all the time and it will be served at one pixel every two cycles. A source that drops `in_valid` stalls the buffer, which keeps both its address and its phase. The output stream has no back-pressure: each reversed pixel appears as a one-cycle `out_valid` pulse, and the consumer must take it. Output is one line behind input.

Top module: `line_mirror_buf`

## Requirements
- R1: While and just after reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.
- R2: A pixel is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for exactly the next cycle and 1 again after it, so at most one pixel is taken per two cycles.
- R3: While `in_ready` is 1 and `in_valid` is 0, `in_ready` stays 1 and no output is produced. A line interrupted this way resumes with the correct order.
- R4: `in_sol` = 1 marks the first pixel of a line. `line_len` (1 to MAX_LEN) is used only on that pixel, and a change of `line_len` elsewhere in the line has no effect.
- R5: Pixels accepted after reset but before the first `in_sol` are discarded and never produce output.
- R6: The first line after reset produces no output.
- R7: For each pixel accepted at edge k of the second or later line after reset, `out_valid` is 1 during exactly the one cycle that follows edge k+1.
- R8: For consecutive lines of equal length L, the j-th output emitted during line n equals pixel L-1-j of line n-1 (j counted from 0).
- R9: `out_data` changes only in a cycle in which `out_valid` is 1, and otherwise holds its last value.
- R10: Reversal is correct at both length limits, L = 1 and L = MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Buffer in read phase, able to take a pixel |
| in_data | input | DATA_W | Input pixel |
| in_sol | input | 1 | First pixel of a line |
| line_len | input | $clog2(MAX_LEN+1) | Line length, sampled with the first pixel |
| out_valid | output | 1 | One-cycle strobe for a reversed pixel |
| out_data | output | DATA_W | Reversed pixel from the previous line |

## Verification
Several kinds of internal fault are visible at the ports. A wrong traversal direction or wrong start address shows as a data mismatch on the very first output of the second line. A phase that fails to hold through a stall shows as a misplaced `in_ready` low in the following cycle. A primed flag that is set too early shows as an `out_valid` pulse during the first line. A write that lands at an address other than the one just read corrupts the next line's output at the matching mirrored position, so it is seen one line later. Stalls in the middle of a line, changes to `line_len` in the middle of a line, stray pixels before the first start, and both length limits are each driven while every output cycle is compared against a model of the previous line in reverse.

// File: rtl/lmb_pkg.sv
package lmb_pkg;
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } phase_e;
endpackage

// File: rtl/lmb_phase_ctrl.sv
module lmb_phase_ctrl
  import lmb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   in_valid,
  output phase_e phase,
  output logic   in_ready,
  output logic   accept
);
  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_READ;
    end else if (phase_q == PH_WRITE) begin
      phase_q <= PH_READ;
    end else if (in_valid) begin
      phase_q <= PH_WRITE;
    end
  end

  assign phase    = phase_q;
  assign in_ready = (phase_q == PH_READ);
  assign accept   = in_ready && in_valid;
endmodule

// File: rtl/lmb_addr_gen.sv
module lmb_addr_gen #(
  parameter int ADDR_W = 9,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              in_sol,
  input  logic [LEN_W-1:0]  line_len,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              keep,
  output logic              emit
);
  logic              seen_q;
  logic              primed_q;
  logic              up_q;
  logic [ADDR_W-1:0] next_q;
  logic              new_up;
  logic              eff_up;
  logic [ADDR_W-1:0] down_start;

  // a new line reverses direction, except the very first one
  assign new_up     = seen_q ? ~up_q : up_q;
  assign eff_up     = in_sol ? new_up : up_q;
  assign down_start = ADDR_W'(line_len - LEN_W'(1));
  assign cur_addr   = in_sol ? (new_up ? '0 : down_start) : next_q;
  assign keep       = seen_q | in_sol;
  assign emit       = in_sol ? seen_q : primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      primed_q <= 1'b0;
      up_q     <= 1'b1;
      next_q   <= '0;
    end else if (accept) begin
      if (in_sol) begin
        seen_q   <= 1'b1;
        primed_q <= seen_q;
        up_q     <= new_up;
      end
      next_q <= eff_up ? cur_addr + ADDR_W'(1) : cur_addr - ADDR_W'(1);
    end
  end
endmodule

// File: rtl/lmb_spram.sv
module lmb_spram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end else begin
        rdata <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/line_mirror_buf.sv
module line_mirror_buf
  import lmb_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 512,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sol,
  input  logic [LEN_W-1:0]  line_len,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int ADDR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  phase_e            phase;
  logic              accept;
  logic [ADDR_W-1:0] cur_addr;
  logic              keep;
  logic              emit;
  logic [ADDR_W-1:0] addr_hold;
  logic [DATA_W-1:0] pix_hold;
  logic              keep_hold;
  logic              emit_hold;
  logic              ram_en;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_rdata;

  lmb_phase_ctrl u_phase (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .phase    (phase),
    .in_ready (in_ready),
    .accept   (accept)
  );

  lmb_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .in_sol   (in_sol),
    .line_len (line_len),
    .cur_addr (cur_addr),
    .keep     (keep),
    .emit     (emit)
  );

  // read phase: fetch old pixel, capture new one; write phase: store it back
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hold <= '0;
      pix_hold  <= '0;
      keep_hold <= 1'b0;
      emit_hold <= 1'b0;
    end else if (accept) begin
      addr_hold <= cur_addr;
      pix_hold  <= in_data;
      keep_hold <= keep;
      emit_hold <= emit;
    end
  end

  assign ram_we   = (phase == PH_WRITE);
  assign ram_en   = accept | (ram_we & keep_hold);
  assign ram_addr = ram_we ? addr_hold : cur_addr;

  lmb_spram #(.DATA_W(DATA_W), .DEPTH(MAX_LEN), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (pix_hold),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (ram_we && keep_hold && emit_hold) begin
      out_valid <= 1'b1;
      out_data  <= ram_rdata;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/line_mirror_buf_chk.sv
module line_mirror_buf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sol,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  logic [1:0] starts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      starts_q <= 2'd0;
    end else if (in_valid && in_ready && in_sol && starts_q != 2'd2) begin
      starts_q <= starts_q + 2'd1;
    end
  end

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  p_ready_back_r2: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);

  p_no_first_line_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (starts_q == 2'd2));

  p_out_latency_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready, 2));

  p_out_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_data) |-> out_valid);
endmodule

bind line_mirror_buf line_mirror_buf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sol    (in_sol),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/line_mirror_buf_tb_top.sv
module line_mirror_buf_tb_top;
  localparam int DW   = 8;
  localparam int MAXL = 512;
  localparam int LW   = $clog2(MAXL + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_sol = 1'b0;
  logic [LW-1:0] line_len = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  int out_cnt  = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] prev_line [MAXL];
  logic [DW-1:0] cur_line  [MAXL];
  int prev_len = 0;
  int line_idx = 0;

  int   starts = 0;
  logic acc_d = 1'b0;
  logic exp_vld = 1'b0;
  logic [DW-1:0] last_out = '0;

  always #10 clk = ~clk;

  line_mirror_buf #(.DATA_W(DW), .MAX_LEN(MAXL)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sol    (in_sol),
    .line_len  (line_len),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference timing: accepted pixel of a primed line -> strobe after next edge
  always @(posedge clk) begin
    if (rst) begin
      starts = 0;
      acc_d   <= 1'b0;
      exp_vld <= 1'b0;
    end else begin
      if (in_valid && in_ready && in_sol && starts < 2) starts = starts + 1;
      acc_d   <= in_valid && in_ready && (starts >= 2);
      exp_vld <= acc_d;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid || exp_vld)
        check(out_valid == exp_vld, "R7 strobe timing", out_valid, exp_vld);
      if (out_valid) begin
        out_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected output", out_data, -1);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(out_data == e, "R8 reversed pixel", out_data, e);
        end
        last_out = out_data;
      end else begin
        check(out_data == last_out, "R9 data hold", out_data, last_out);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sol = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    prev_len = 0; line_idx = 0; last_out = '0;
    check(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    check(out_data == '0, "R1 data after reset", out_data, 0);
  endtask

  // drive at negedge, wait for handshake, then confirm the write-phase gap
  task automatic put_px(input logic [DW-1:0] d, input bit s);
    bit took;
    took = 1'b0;
    in_valid = 1'b1; in_data = d; in_sol = s;
    while (!took) begin
      took = in_ready;
      @(posedge clk);
      @(negedge clk);
    end
    check(in_ready == 1'b0, "R2 ready low in write phase", in_ready, 0);
    in_sol = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(in_ready == 1'b1, "R3 ready held while idle", in_ready, 1);
    end
  endtask

  task automatic send_line(input int len, input int seed, input int gap_every, input bit wiggle_len);
    for (int i = 0; i < len; i++) cur_line[i] = DW'(seed * 37 + i * 13 + i / 7);
    if (line_idx >= 1 && prev_len == len)
      for (int i = len - 1; i >= 0; i--) exp_q.push_back(prev_line[i]);
    for (int i = 0; i < len; i++) begin
      if (i == 0) line_len = LW'(len);
      else if (wiggle_len) line_len = LW'((seed + i) % MAXL + 1);
      put_px(cur_line[i], i == 0);
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) idle(3);
    end
    in_valid = 1'b0;
    for (int i = 0; i < len; i++) prev_line[i] = cur_line[i];
    prev_len = len;
    line_idx++;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all reversed pixels emitted", exp_q.size(), 0);
  endtask

  task automatic t_first_line();
    int c0;
    do_reset();
    c0 = out_cnt;
    send_line(8, 1, 0, 1'b0);
    check(out_cnt == c0, "R6 no output on first line", out_cnt - c0, 0);
  endtask

  task automatic t_reverse();
    int c0;
    for (int k = 0; k < 3; k++) begin
      c0 = out_cnt;
      send_line(8, 2 + k, 0, 1'b0);
      check(out_cnt - c0 == 8, "R8 one output per pixel", out_cnt - c0, 8);
    end
  endtask

  task automatic t_stall();
    int c0;
    c0 = out_cnt;
    send_line(8, 9, 3, 1'b0);
    send_line(8, 10, 2, 1'b0);
    check(out_cnt - c0 == 16, "R3 stalled lines complete", out_cnt - c0, 16);
  endtask

  task automatic t_len_wiggle();
    int c0;
    do_reset();
    c0 = out_cnt;
    send_line(12, 20, 0, 1'b1);
    send_line(12, 21, 0, 1'b1);
    send_line(12, 22, 4, 1'b1);
    check(out_cnt - c0 == 24, "R4 length used only at line start", out_cnt - c0, 24);
  endtask

  task automatic t_pre_sol();
    int c0;
    do_reset();
    c0 = out_cnt;
    for (int i = 0; i < 5; i++) put_px(DW'(8'hA0 + i), 1'b0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_cnt == c0, "R5 pre-start pixels dropped", out_cnt - c0, 0);
    send_line(6, 30, 0, 1'b0);
    check(out_cnt == c0, "R5 no output before second line", out_cnt - c0, 0);
    send_line(6, 31, 0, 1'b0);
    check(out_cnt - c0 == 6, "R5 only real line reversed", out_cnt - c0, 6);
  endtask

  task automatic t_len_one();
    int c0;
    do_reset();
    c0 = out_cnt;
    for (int k = 0; k < 4; k++) send_line(1, 40 + k, 0, 1'b0);
    check(out_cnt - c0 == 3, "R10 length one", out_cnt - c0, 3);
  endtask

  task automatic t_len_max();
    int c0;
    do_reset();
    c0 = out_cnt;
    send_line(MAXL, 50, 0, 1'b0);
    send_line(MAXL, 51, 0, 1'b0);
    send_line(MAXL, 52, 0, 1'b0);
    check(out_cnt - c0 == 2 * MAXL, "R10 maximum length", out_cnt - c0, 2 * MAXL);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    t_first_line();
    t_reverse();
    t_stall();
    t_len_wiggle();
    t_pre_sol();
    t_len_one();
    t_len_max();
    finish_run();
  end
endmodule